// File: doc/BRIEF.md
# Cascaded Two-Line Pixel Delay

This block keeps the last lines of an 8-bit pixel stream so that a line-based filter sees three vertically adjacent pixels at once. The live input, the same column one line earlier and the same column two lines earlier are all available. It holds two line stores. The first is filled on the write clock under its own enable and reset. The second is filled on the read clock from the word that the first store returns. One read strobe therefore yields a 1-line delayed word and a 2-line delayed word together.

The write and read sides run on unrelated clocks. The delay is not a fixed constant. It equals the number of words the write address leads the read address. The user sets this lead either by the spacing between the write reset and the read reset, or by holding the read side idle while writing continues. When the read side is idle, both output buses float, so several of these blocks can share a bus.

Top module: `dual_line_delay`

## Requirements
- R1: Each line store holds LINE_WORDS words of PIX_W bits (defaults 5120 and 8). Suppose the write address leads the read address by exactly LINE_WORDS. Then `dly1_o` returns the word written LINE_WORDS writes earlier.
- R2: On a `wclk_i` rising edge with `wr_en_ni` low and `wr_rst_ni` high, `data_i` is stored at the first store's write address, and that address advances by one.
- R3: On a `wclk_i` edge with `wr_en_ni` high, nothing is stored and the first store's write address keeps its value.
- R4: A `wclk_i` edge with `wr_rst_ni` low returns only the first store's write address to 0. The read addresses and the stored words are unchanged.
- R5: On an `rclk_i` rising edge with `rd_en_ni` low and `rd_rst_ni` high, the words at both read addresses appear on `dly1_o` and `dly2_o` after that edge. Both read addresses advance together.
- R6: On that same edge, the word placed on `dly1_o` is also written into the second store, and its write address advances. `dly2_o` therefore equals the `dly1_o` word from LINE_WORDS reads earlier.
- R7: On an `rclk_i` edge with `rd_en_ni` high, both read addresses and the second store's write address hold. `dly1_oe_o` and `dly2_oe_o` go low and both buses go to high impedance. Both enables are low after `rst_ni`.
- R8: An `rclk_i` edge with `rd_rst_ni` low returns the first store's read address and both addresses of the second store to 0.
- R9: If K words are written after a write reset before reads begin following a read reset, then `dly1_o` returns the input delayed by K writes.
- R10: Every address counter steps from LINE_WORDS-1 to 0.
- R11: On an edge where a reset and its enable are both low, the reset wins. No word is stored or read, and the output enables stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous reset of all counters and output registers, active low |
| wr_en_ni | input | 1 | Write enable, active low |
| wr_rst_ni | input | 1 | Synchronous write-address reset, active low |
| data_i | input | PIX_W | Input pixel |
| rd_en_ni | input | 1 | Read enable, active low |
| rd_rst_ni | input | 1 | Synchronous read-side reset, active low |
| dly1_o | output | PIX_W | One-line delayed pixel, tri-state |
| dly2_o | output | PIX_W | Two-line delayed pixel, tri-state |
| dly1_oe_o | output | 1 | Drive enable of `dly1_o` |
| dly2_oe_o | output | 1 | Drive enable of `dly2_o` |

## Verification
A write or read address that slips by one word does not stay hidden. It shifts every following `dly1_o` word against the input stream, so the very next read after the slip is wrong. An error in the second store's pointers shows up on `dly2_o` only after one full line of reads, because that store is not read back until then. A wrong drive-enable state shows at the first `rclk_i` edge after the read enable changes.

// File: rtl/dld_pkg.sv
package dld_pkg;
  localparam int unsigned LINE_WORDS_DEF = 5120;
  localparam int unsigned PIX_W_DEF      = 8;

  typedef enum logic [1:0] {OP_IDLE, OP_CLEAR, OP_STEP} port_op_e;

  // reset has priority over enable
  function automatic port_op_e decode_op(input logic rst_n, input logic en_n);
    if (!rst_n)     return OP_CLEAR;
    else if (!en_n) return OP_STEP;
    else            return OP_IDLE;
  endfunction
endpackage

// File: rtl/dld_addr_ctr.sv
module dld_addr_ctr #(
  parameter int unsigned DEPTH = 5120,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (clr_i)  addr_o <= '0;
    else if (step_i) addr_o <= (addr_o == LAST) ? '0 : addr_o + AW'(1);
  end
endmodule

// File: rtl/dld_line_ram.sv
module dld_line_ram #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 5120,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // combinational read; caller registers it
  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/dual_line_delay.sv
module dual_line_delay
  import dld_pkg::*;
#(
  parameter int unsigned PIX_W      = PIX_W_DEF,
  parameter int unsigned LINE_WORDS = LINE_WORDS_DEF,
  localparam int unsigned AW        = $clog2(LINE_WORDS)
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             wr_en_ni,
  input  logic             wr_rst_ni,
  input  logic [PIX_W-1:0] data_i,
  input  logic             rd_en_ni,
  input  logic             rd_rst_ni,
  output logic [PIX_W-1:0] dly1_o,
  output logic [PIX_W-1:0] dly2_o,
  output logic             dly1_oe_o,
  output logic             dly2_oe_o
);
  port_op_e wr_op, rd_op;
  logic wr_step, wr_clr, rd_step, rd_clr;
  logic [AW-1:0] wp1, rp1, wp2, rp2;
  logic [PIX_W-1:0] line1_word, line2_word;
  logic [PIX_W-1:0] q1, q2;
  logic q1_oe, q2_oe;

  assign wr_op   = decode_op(wr_rst_ni, wr_en_ni);
  assign rd_op   = decode_op(rd_rst_ni, rd_en_ni);
  assign wr_step = (wr_op == OP_STEP);
  assign wr_clr  = (wr_op == OP_CLEAR);
  assign rd_step = (rd_op == OP_STEP);
  assign rd_clr  = (rd_op == OP_CLEAR);

  // stage 1: write side on wclk, read side on rclk
  dld_addr_ctr #(.DEPTH(LINE_WORDS)) u_wp1 (
    .clk_i(wclk_i), .rst_ni(rst_ni), .clr_i(wr_clr), .step_i(wr_step), .addr_o(wp1)
  );
  dld_addr_ctr #(.DEPTH(LINE_WORDS)) u_rp1 (
    .clk_i(rclk_i), .rst_ni(rst_ni), .clr_i(rd_clr), .step_i(rd_step), .addr_o(rp1)
  );
  dld_line_ram #(.W(PIX_W), .DEPTH(LINE_WORDS)) u_mem1 (
    .wclk_i(wclk_i), .we_i(wr_step), .waddr_i(wp1), .wdata_i(data_i),
    .raddr_i(rp1), .rdata_o(line1_word)
  );

  // stage 2: both ports on rclk, fed by stage-1 read word
  dld_addr_ctr #(.DEPTH(LINE_WORDS)) u_wp2 (
    .clk_i(rclk_i), .rst_ni(rst_ni), .clr_i(rd_clr), .step_i(rd_step), .addr_o(wp2)
  );
  dld_addr_ctr #(.DEPTH(LINE_WORDS)) u_rp2 (
    .clk_i(rclk_i), .rst_ni(rst_ni), .clr_i(rd_clr), .step_i(rd_step), .addr_o(rp2)
  );
  dld_line_ram #(.W(PIX_W), .DEPTH(LINE_WORDS)) u_mem2 (
    .wclk_i(rclk_i), .we_i(rd_step), .waddr_i(wp2), .wdata_i(line1_word),
    .raddr_i(rp2), .rdata_o(line2_word)
  );

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q1    <= '0;
      q2    <= '0;
      q1_oe <= 1'b0;
      q2_oe <= 1'b0;
    end else begin
      q1_oe <= rd_step;
      q2_oe <= rd_step;
      if (rd_step) begin
        q1 <= line1_word;
        q2 <= line2_word;
      end
    end
  end

  assign dly1_oe_o = q1_oe;
  assign dly2_oe_o = q2_oe;
  assign dly1_o    = q1_oe ? q1 : 'z;
  assign dly2_o    = q2_oe ? q2 : 'z;
endmodule

// File: rtl/dld_chk.sv
module dld_chk #(
  parameter int unsigned DEPTH = 5120,
  parameter int unsigned AW    = 13
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wr_en_ni,
  input logic          wr_rst_ni,
  input logic          rd_en_ni,
  input logic          rd_rst_ni,
  input logic [AW-1:0] wp1,
  input logic [AW-1:0] rp1,
  input logic [AW-1:0] wp2,
  input logic [AW-1:0] rp2,
  input logic          q1_oe,
  input logic          q2_oe
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R2 R10
  wr_advance_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_rst_ni && !wr_en_ni) |=> wp1 == (($past(wp1) == LAST) ? '0 : $past(wp1) + AW'(1)));

  // R3
  wr_hold_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_rst_ni && wr_en_ni) |=> $stable(wp1));

  // R4 R11
  wr_clear_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !wr_rst_ni |=> wp1 == '0);

  // R5 R10
  rd_advance_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_rst_ni && !rd_en_ni) |=> rp1 == (($past(rp1) == LAST) ? '0 : $past(rp1) + AW'(1)));

  // R6
  wr2_advance_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_rst_ni && !rd_en_ni) |=> wp2 == (($past(wp2) == LAST) ? '0 : $past(wp2) + AW'(1)));

  // R7
  rd_idle_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_rst_ni && rd_en_ni) |=> (!q1_oe && !q2_oe && $stable(rp1) && $stable(rp2) && $stable(wp2)));

  // R8 R11
  rd_clear_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !rd_rst_ni |=> (rp1 == '0 && rp2 == '0 && wp2 == '0 && !q1_oe && !q2_oe));

  // R10
  addr_range_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rp1 <= LAST && rp2 <= LAST && wp2 <= LAST));
endmodule

bind dual_line_delay dld_chk #(.DEPTH(LINE_WORDS), .AW(AW)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni),
  .wr_en_ni(wr_en_ni), .wr_rst_ni(wr_rst_ni),
  .rd_en_ni(rd_en_ni), .rd_rst_ni(rd_rst_ni),
  .wp1(wp1), .rp1(rp1), .wp2(wp2), .rp2(rp2),
  .q1_oe(q1_oe), .q2_oe(q2_oe)
);

// File: tb/dual_line_delay_test.sv
`timescale 1ns/1ps
module dual_line_delay_test;
  localparam int DEPTH = 5120;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_en_n = 1'b1, wr_rst_n = 1'b1, rd_en_n = 1'b1, rd_rst_n = 1'b1;
  logic [7:0] din = '0;
  wire  [7:0] dly1, dly2;
  wire        oe1, oe2;

  always #10 wclk = ~wclk;   // 50 MHz
  always #13 rclk = ~rclk;   // unrelated read clock

  dual_line_delay uut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_en_ni(wr_en_n), .wr_rst_ni(wr_rst_n), .data_i(din),
    .rd_en_ni(rd_en_n), .rd_rst_ni(rd_rst_n),
    .dly1_o(dly1), .dly2_o(dly2), .dly1_oe_o(oe1), .dly2_oe_o(oe2)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur = "R1";
  logic [7:0] exp1_q[$];
  logic [7:0] exp2_q[$];
  logic pend = 1'b0;
  int pix_n = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pix(input int n);
    return 8'((n * 29) + (n >> 8) + 3);
  endfunction

  // driver
  task automatic wr_word(input logic [7:0] d, input bit push);
    @(negedge wclk); din = d; wr_en_n = 1'b0;
    @(negedge wclk); wr_en_n = 1'b1;
    if (push) exp1_q.push_back(d);
  endtask

  task automatic wr_next();
    wr_word(pix(pix_n), 1'b1);
    pix_n++;
  endtask

  task automatic rd_word();
    @(negedge rclk); rd_en_n = 1'b0;
    @(negedge rclk); rd_en_n = 1'b1;
    #2;
  endtask

  task automatic wr_reset(input bit with_en, input logic [7:0] d);
    @(negedge wclk); wr_rst_n = 1'b0; wr_en_n = !with_en; din = d;
    @(negedge wclk); wr_rst_n = 1'b1; wr_en_n = 1'b1;
    exp1_q.delete();
  endtask

  task automatic rd_reset(input bit with_en);
    @(negedge rclk); rd_rst_n = 1'b0; rd_en_n = !with_en;
    @(negedge rclk); rd_rst_n = 1'b1; rd_en_n = 1'b1;
    exp2_q.delete();
    chk("R11", {6'd0, oe1, oe2}, 8'd0);
  endtask

  // monitor
  always @(posedge rclk) pend <= rst_n && rd_rst_n && !rd_en_n;

  always @(negedge rclk) begin
    if (pend) begin
      logic [7:0] e1;
      chk("R5", {6'd0, oe1, oe2}, 8'd3);
      if (exp1_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL %s act=%h exp=none (queue empty)", cur, dly1);
      end else begin
        e1 = exp1_q.pop_front();
        chk(cur, dly1, e1);
        exp2_q.push_back(e1);
        if (exp2_q.size() > DEPTH) chk("R6", dly2, exp2_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge wclk);
    chk("R7", {6'd0, oe1, oe2}, 8'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge rclk);
    chk("R7", {6'd0, oe1, oe2}, 8'd0);

    // R4: write reset moves only the write address
    wr_reset(1'b0, 8'h00);
    rd_reset(1'b0);
    for (int i = 0; i < 5; i++) wr_word(8'hA0 + 8'(i), 1'b0);
    wr_reset(1'b0, 8'h00);
    wr_word(8'hB0, 1'b0);
    wr_word(8'hB1, 1'b0);
    exp1_q.delete();
    exp1_q.push_back(8'hB0); exp1_q.push_back(8'hB1);
    exp1_q.push_back(8'hA2); exp1_q.push_back(8'hA3); exp1_q.push_back(8'hA4);
    cur = "R4";
    for (int i = 0; i < 5; i++) rd_word();

    // R9 R11: short lead of 3 words, resets applied with enables low
    wr_reset(1'b1, 8'hEE);
    rd_reset(1'b1);
    for (int i = 0; i < 3; i++) wr_next();
    cur = "R9";
    for (int i = 0; i < 30; i++) begin
      rd_word();
      wr_next();
    end

    // R1 R6 R10: full-line lead, runs past the wrap twice
    wr_reset(1'b0, 8'h00);
    rd_reset(1'b0);
    for (int i = 0; i < DEPTH; i++) wr_next();
    for (int i = 0; i < 2 * DEPTH + 40; i++) begin
      cur = (i < DEPTH) ? "R1" : "R10";
      rd_word();
      if (i % 997 == 500) begin
        // R3: data toggles with write disabled
        @(negedge wclk); din = 8'h5A;
        @(negedge wclk); din = 8'hA5;
        @(negedge wclk);
        // R7: read idle for a few edges
        repeat (3) @(negedge rclk);
        chk("R7", {6'd0, oe1, oe2}, 8'd0);
        chk("R7", dly1_z(), 8'd1);
      end
      wr_next();
      if (i % 997 == 500) cur = "R3";
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  function automatic logic [7:0] dly1_z();
    return {7'd0, !oe1};
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R5 watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule